// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped cache in the instruction fetch stage. It maps the address of the instruction being fetched to a predicted next fetch address. It is looked up with the current fetch PC before the instruction has been decoded. The answer is produced in the same cycle, so fetch can turn toward a branch target with no lost cycle. An entry holds only branches that are expected to be taken. A hit therefore redirects fetch to the stored target, and a miss lets fetch continue with the next sequential word.

A second port, driven from the stage that resolves branches, keeps the table current. When a taken branch missed, or hit with the wrong target, its entry is written with the full tag and the correct target. When a branch that hit turns out not taken, its entry is invalidated. That port also compares the real next PC with the PC that fetch predicted. When they differ, it raises a registered mispredict flag together with the address to restart from.

Top module: `btb_top`

## Requirements
- R1: `pred_hit` is 1 in the same cycle when `fetch_valid` is 1 and the entry at index `fetch_pc[IDX_W+1:2]` is valid and holds the tag `fetch_pc[PC_W-1:IDX_W+2]`. Otherwise it is 0.
- R2: On a hit, `fetch_next_pc` equals the target stored in the matching entry, in the same cycle.
- R3: When there is no hit (a miss, or `fetch_valid` is 0), `fetch_next_pc` equals `fetch_pc + 4`.
- R4: An update with `upd_taken`=1 writes valid=1, the tag of `upd_pc` and `upd_target` into the entry indexed by `upd_pc`. This happens when `upd_pred_hit`=0, or when `upd_pred_pc` differs from `upd_target`. Lookups see the new entry from the next cycle on.
- R5: An update with `upd_taken`=0 and `upd_pred_hit`=1 clears the valid bit of the indexed entry, but only if that entry's stored tag equals the tag of `upd_pc`. An entry of another branch at that index is left as it was.
- R6: One cycle after an update whose actual next PC differs from `upd_pred_pc`, `mispredict` is 1 and `redirect_pc` holds the actual next PC. The actual next PC is `upd_target` when the branch is taken and `upd_pc + 4` when it is not.
- R7: `mispredict` is 0 in the cycle after an update whose actual next PC equals `upd_pred_pc`, and in the cycle after a cycle with no update.
- R8: Synchronous reset (`rst`=1) invalidates every entry and clears `mispredict`.
- R9: A lookup in the same cycle as an update to the same entry sees the contents from before that update.
- R10: Two PCs that share an index but differ in tag never hit on each other's entry. A write for one replaces the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch lookup is presented this cycle |
| fetch_pc | input | PC_W | Address of the instruction being fetched |
| pred_hit | output | 1 | Fetched instruction is a predicted-taken branch |
| fetch_next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | PC_W | Resolved taken target |
| upd_pred_hit | input | 1 | The branch hit in the buffer when it was fetched |
| upd_pred_pc | input | PC_W | Next PC that was predicted at fetch |
| mispredict | output | 1 | Registered: prediction was wrong, restart fetch |
| redirect_pc | output | PC_W | Registered: correct next fetch address |

## Verification
A wrong valid bit, tag or target in one entry shows on `pred_hit` and `fetch_next_pc` in the same cycle that a fetch touches that index. The bench sweeps every index after each kind of update, so any corrupted entry is caught on the next pass over the table. A wrong write or clear decision appears one lookup later, and a wrong mispredict decision appears on `mispredict` and `redirect_pc` exactly one clock after the update. Same-index aliases and same-cycle update-and-lookup are swept for every entry, so a missing tag bit or an unintended bypass shows at once.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_FILL  = 2'd1,
    WR_CLEAR = 2'd2
  } wr_cmd_t;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned OFFS_W     = 2;
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 26,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  // lookup read port
  input  logic [IDX_W-1:0] rd0_idx,
  output logic             rd0_valid,
  output logic [TAG_W-1:0] rd0_tag,
  output logic [PC_W-1:0]  rd0_tgt,
  // resolve read port
  input  logic [IDX_W-1:0] rd1_idx,
  output logic             rd1_valid,
  output logic [TAG_W-1:0] rd1_tag,
  // single write port
  input  wr_cmd_t          wr_cmd,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  // valid bits live in flops so that reset can clear them in one cycle
  logic [DEPTH-1:0] vld_q;
  // tag and target arrays have no reset, so they map to distributed RAM
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      case (wr_cmd)
        WR_FILL:  vld_q[wr_idx] <= 1'b1;
        WR_CLEAR: vld_q[wr_idx] <= 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_cmd == WR_FILL) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  // asynchronous reads: results are ready within the fetch cycle
  assign rd0_valid = vld_q[rd0_idx];
  assign rd0_tag   = tag_mem[rd0_idx];
  assign rd0_tgt   = tgt_mem[rd0_idx];
  assign rd1_valid = vld_q[rd1_idx];
  assign rd1_tag   = tag_mem[rd1_idx];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 26,
  parameter int unsigned PC_W  = 32
) (
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_tgt,
  output logic             hit,
  output logic [PC_W-1:0]  next_pc
);
  logic [TAG_W-1:0] pc_tag;
  logic [PC_W-1:0]  seq_pc;

  assign rd_idx  = fetch_pc[OFFS_W +: IDX_W];
  assign pc_tag  = fetch_pc[OFFS_W+IDX_W +: TAG_W];
  assign seq_pc  = fetch_pc + PC_W'(INSN_BYTES);

  always_comb begin
    hit     = fetch_valid && rd_valid && (rd_tag == pc_tag);
    next_pc = hit ? rd_tgt : seq_pc;
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 26,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_target,
  input  logic             upd_pred_hit,
  input  logic [PC_W-1:0]  upd_pred_pc,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  output wr_cmd_t          wr_cmd,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output logic [PC_W-1:0]  wr_tgt,
  output logic             mispredict,
  output logic [PC_W-1:0]  redirect_pc
);
  logic [PC_W-1:0] actual_pc;
  logic            wrong_tgt;
  logic            own_entry;
  logic            miss_q;
  logic [PC_W-1:0] redir_q;

  assign rd_idx = upd_pc[OFFS_W +: IDX_W];
  assign wr_idx = rd_idx;
  assign wr_tag = upd_pc[OFFS_W+IDX_W +: TAG_W];
  assign wr_tgt = upd_target;

  always_comb begin
    actual_pc = upd_taken ? upd_target : (upd_pc + PC_W'(INSN_BYTES));
    wrong_tgt = (upd_pred_pc != upd_target);
    own_entry = rd_valid && (rd_tag == wr_tag);
    wr_cmd    = WR_NONE;
    if (upd_valid) begin
      if (upd_taken) begin
        if (!upd_pred_hit || wrong_tgt) wr_cmd = WR_FILL;
      end else if (upd_pred_hit && own_entry) begin
        wr_cmd = WR_CLEAR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_q  <= 1'b0;
      redir_q <= '0;
    end else begin
      miss_q  <= upd_valid && (actual_pc != upd_pred_pc);
      redir_q <= actual_pc;
    end
  end

  assign mispredict  = miss_q;
  assign redirect_pc = redir_q;
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] fetch_next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_pred_hit,
  input  logic [PC_W-1:0] upd_pred_pc,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int unsigned TAG_W = PC_W - IDX_W - OFFS_W;

  logic [IDX_W-1:0] rd0_idx, rd1_idx, wr_idx;
  logic             rd0_valid, rd1_valid;
  logic [TAG_W-1:0] rd0_tag, rd1_tag, wr_tag;
  logic [PC_W-1:0]  rd0_tgt, wr_tgt;
  wr_cmd_t          wr_cmd;

  btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .rd0_idx   (rd0_idx),
    .rd0_valid (rd0_valid),
    .rd0_tag   (rd0_tag),
    .rd0_tgt   (rd0_tgt),
    .rd1_idx   (rd1_idx),
    .rd1_valid (rd1_valid),
    .rd1_tag   (rd1_tag),
    .wr_cmd    (wr_cmd),
    .wr_idx    (wr_idx),
    .wr_tag    (wr_tag),
    .wr_tgt    (wr_tgt)
  );

  btb_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_lookup (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .rd_idx      (rd0_idx),
    .rd_valid    (rd0_valid),
    .rd_tag      (rd0_tag),
    .rd_tgt      (rd0_tgt),
    .hit         (pred_hit),
    .next_pc     (fetch_next_pc)
  );

  btb_resolve #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_resolve (
    .clk          (clk),
    .rst          (rst),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target),
    .upd_pred_hit (upd_pred_hit),
    .upd_pred_pc  (upd_pred_pc),
    .rd_idx       (rd1_idx),
    .rd_valid     (rd1_valid),
    .rd_tag       (rd1_tag),
    .wr_cmd       (wr_cmd),
    .wr_idx       (wr_idx),
    .wr_tag       (wr_tag),
    .wr_tgt       (wr_tgt),
    .mispredict   (mispredict),
    .redirect_pc  (redirect_pc)
  );
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_hit,
  input logic [PC_W-1:0] fetch_next_pc,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target,
  input logic [PC_W-1:0] upd_pred_pc,
  input logic            mispredict,
  input logic [PC_W-1:0] redirect_pc
);
  // R3: no fetch request means no hit and a sequential next address
  a_r3_idle_sequential: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> (!pred_hit && fetch_next_pc == fetch_pc + PC_W'(4)));

  // R8: the first lookup after reset finds every entry invalid
  a_r8_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pred_hit && !mispredict));

  // R6: a taken branch whose target was not predicted redirects to the target
  a_r6_taken_redirect: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_target != upd_pred_pc)
    |=> (mispredict && redirect_pc == $past(upd_target)));

  // R6: a not-taken branch predicted elsewhere redirects to the fall-through
  a_r6_fallthrough_redirect: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && upd_pc + PC_W'(4) != upd_pred_pc)
    |=> (mispredict && redirect_pc == $past(upd_pc) + PC_W'(4)));

  // R7: no update, no mispredict
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !mispredict);

  // R7: a correct prediction raises nothing
  a_r7_correct: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_target == upd_pred_pc) |=> !mispredict);
endmodule

bind btb_top btb_chk #(.PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fetch_valid   (fetch_valid),
  .fetch_pc      (fetch_pc),
  .pred_hit      (pred_hit),
  .fetch_next_pc (fetch_next_pc),
  .upd_valid     (upd_valid),
  .upd_pc        (upd_pc),
  .upd_taken     (upd_taken),
  .upd_target    (upd_target),
  .upd_pred_pc   (upd_pred_pc),
  .mispredict    (mispredict),
  .redirect_pc   (redirect_pc)
);

// File: tb/sim_btb_top.sv
`timescale 1ns/1ps
module sim_btb_top;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_hit;
  logic [PC_W-1:0] fetch_next_pc;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic [PC_W-1:0] upd_target = '0;
  logic            upd_pred_hit = 1'b0;
  logic [PC_W-1:0] upd_pred_pc = '0;
  logic            mispredict;
  logic [PC_W-1:0] redirect_pc;

  int checks = 0;
  int failures = 0;

  // reference table built from the requirements
  logic             m_v   [DEPTH];
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [PC_W-1:0]  m_tgt [DEPTH];

  always #5 clk = ~clk;

  btb_top #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .fetch_next_pc(fetch_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_pred_hit(upd_pred_hit),
    .upd_pred_pc(upd_pred_pc),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  function automatic logic [PC_W-1:0] mk_pc(input int tag, input int idx);
    logic [TAG_W-1:0] t = TAG_W'(tag);
    logic [IDX_W-1:0] x = IDX_W'(idx);
    return {t, x, 2'b00};
  endfunction

  function automatic int tag_a(input int i);
    return 'h1234 + 7 * i;
  endfunction

  function automatic int tag_b(input int i);
    return 'h0777 + 13 * i;
  endfunction

  task automatic chk(input string req, input string ctx,
                     input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s) actual=%h expected=%h", req, ctx, act, exp);
    end
  endtask

  // one clock: drive at negedge, check lookup, clock, check resolve outputs
  task automatic step(input string ctx,
                      input logic fv, input logic [PC_W-1:0] fpc,
                      input logic uv, input logic [PC_W-1:0] upc,
                      input logic utk, input logic [PC_W-1:0] utgt,
                      input logic uph, input logic [PC_W-1:0] upp);
    int fi, ui;
    logic [TAG_W-1:0] ft, ut;
    logic e_hit, e_mp;
    logic [PC_W-1:0] e_next, act_next;
    @(negedge clk);
    fetch_valid = fv; fetch_pc = fpc;
    upd_valid = uv; upd_pc = upc; upd_taken = utk; upd_target = utgt;
    upd_pred_hit = uph; upd_pred_pc = upp;
    #2;
    fi = int'(fpc[IDX_W+1:2]); ft = fpc[PC_W-1:IDX_W+2];
    e_hit  = fv && m_v[fi] && (m_tag[fi] == ft);
    e_next = e_hit ? m_tgt[fi] : fpc + 4;
    chk("R1", ctx, PC_W'(pred_hit), PC_W'(e_hit));
    chk(e_hit ? "R2" : "R3", ctx, fetch_next_pc, e_next);
    // model update lands at the coming edge
    ui = int'(upc[IDX_W+1:2]); ut = upc[PC_W-1:IDX_W+2];
    act_next = utk ? utgt : upc + 4;
    e_mp = uv && (act_next != upp);
    if (uv) begin
      if (utk) begin
        if (!uph || upp != utgt) begin
          m_v[ui] = 1'b1; m_tag[ui] = ut; m_tgt[ui] = utgt;
        end
      end else if (uph && m_v[ui] && m_tag[ui] == ut) begin
        m_v[ui] = 1'b0;
      end
    end
    @(posedge clk); #1;
    chk(e_mp ? "R6" : "R7", ctx, PC_W'(mispredict), PC_W'(e_mp));
    if (e_mp) chk("R6", ctx, redirect_pc, act_next);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd_valid = 1'b0; fetch_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    #1;
    chk("R8", "mispredict after reset", PC_W'(mispredict), '0);
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pa, pb;
    do_reset();

    // R8/R3: empty table misses everywhere
    for (int i = 0; i < DEPTH; i++)
      step("R8 empty sweep", 1, mk_pc(tag_a(i), i), 0, '0, 0, '0, 0, '0);

    // R4 fill on miss; R9 same-cycle lookup of the same entry sees the old state
    for (int i = 0; i < DEPTH; i++) begin
      pa = mk_pc(tag_a(i), i);
      step("R4 fill, R9 same-cycle", 1, pa, 1, pa, 1,
           32'h8000_0000 + 32'(i * 64), 0, pa + 4);
    end

    // R1/R2: every entry hits with its target
    for (int i = 0; i < DEPTH; i++)
      step("R2 hit sweep", 1, mk_pc(tag_a(i), i), 0, '0, 0, '0, 0, '0);

    // R10: aliases miss; R5: not-taken for an alias leaves the owner
    for (int i = 0; i < DEPTH; i++) begin
      pb = mk_pc(tag_b(i), i);
      step("R10 alias miss", 1, pb, 0, '0, 0, '0, 0, '0);
      step("R5 alias clear ignored", 1, pb, 1, pb, 0, '0, 1, pb + 4);
      step("R5 owner kept", 1, mk_pc(tag_a(i), i), 0, '0, 0, '0, 0, '0);
    end

    // R4 rewrite on wrong target (odd), R7 correct hit leaves entry (even)
    for (int i = 0; i < DEPTH; i++) begin
      pa = mk_pc(tag_a(i), i);
      if (i % 2 == 1)
        step("R4 wrong target rewrite", 0, '0, 1, pa, 1,
             32'h4000_0000 + 32'(i * 16), 1, 32'h8000_0000 + 32'(i * 64));
      else
        step("R7 correct hit", 0, '0, 1, pa, 1,
             32'h8000_0000 + 32'(i * 64), 1, 32'h8000_0000 + 32'(i * 64));
      step("R4 lookup after update", 1, pa, 0, '0, 0, '0, 0, '0);
    end

    // R5 clear on not-taken for even indices, R6 fall-through redirect
    for (int i = 0; i < DEPTH; i += 2) begin
      pa = mk_pc(tag_a(i), i);
      step("R5 clear own", 1, pa, 1, pa, 0, '0, 1, 32'h8000_0000 + 32'(i * 64));
      step("R5 cleared lookup", 1, pa, 0, '0, 0, '0, 0, '0);
    end

    // R10: alias write replaces the owner
    pa = mk_pc(tag_a(3), 3); pb = mk_pc(tag_b(3), 3);
    step("R10 alias write", 0, '0, 1, pb, 1, 32'h0000_1000, 0, pb + 4);
    step("R10 new owner hits", 1, pb, 0, '0, 0, '0, 0, '0);
    step("R10 old owner misses", 1, pa, 0, '0, 0, '0, 0, '0);

    // R3: fetch_valid low at a valid entry gives no hit
    step("R3 fetch idle", 0, mk_pc(tag_a(5), 5), 0, '0, 0, '0, 0, '0);

    // R8: reset mid-run empties the table
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      step("R8 post-reset a", 1, mk_pc(tag_a(i), i), 0, '0, 0, '0, 0, '0);
      step("R8 post-reset b", 1, mk_pc(tag_b(i), i), 0, '0, 0, '0, 0, '0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule